// File: doc/BRIEF.md
# Cache capacity bitmask checker

This block admits or refuses a capacity bitmask write for one cache instance. It holds a small table of class-of-service entries. Each entry has a way mask and a mode: shareable, exclusive or pseudo-locked. A command names a target entry, a requested mask and a requested mode. The block first checks the shape of the mask against the configured limits: the valid way mask, the minimum run length and whether the set bits must be contiguous. It then checks the mask against the masks that the other entries already hold. If every check passes, the target entry is overwritten.

The verdict is registered and comes out as an error code that stays put until the next command. A per-way usage code is derived at all times from the whole table and from the hardware-shareable mask. A combinational read port shows any stored entry.

Top module: `cbm_mask_checker`

## Requirements
- R1: `rsp_valid` pulses for exactly the one cycle after each cycle in which `cmd_valid` is high. `rsp_err` holds the verdict of the most recent command until the next command arrives.
- R2: A mask with any bit set outside `full_mask` is refused with code 3 (out of range). This check has the highest priority.
- R3: A mask whose longest run of consecutive set bits is shorter than `min_run` is refused with code 2 (too few bits). As a result, an all-zero mask is refused whenever `min_run` is at least 1. This check ranks second.
- R4: When `need_contig` is 1, a mask whose set bits form more than one run is refused with code 1 (non-contiguous). For example, 0x05 is refused and 0x06 is accepted. This check ranks third.
- R5: A shareable request (`cmd_mode` 0, with 3 treated as 0) is refused with code 4 if it overlaps the mask of any other entry that is in mode 1 or mode 2.
- R6: An exclusive request (`cmd_mode` 1) is refused with code 4 if it overlaps the mask of any other entry in any mode, entry 0 included.
- R7: A pseudo-lock request (`cmd_mode` 2) is refused with code 5 (bits not unused) if any requested bit is in another entry's mask or in `hw_share_mask`. On success the entry's mode reads 2 (pseudo-locked).
- R8: An accepted command (code 0, `rsp_ok` 1) writes its mask and mode into the target entry. A refused command leaves every entry unchanged. `rd_mask` and `rd_mode` show the entry selected by `rd_idx`.
- R9: `usage` holds a 3-bit code for each way w, in bits [3w+2:3w]. The code is 5 if a pseudo-locked entry holds the way. Otherwise it is 4 if an exclusive entry holds it. Otherwise, if a shareable entry holds it, the code is 2 when the way is hardware-shareable and 3 when it is not. If no entry holds the way, the code is 1 when it is hardware-shareable and 0 when it is not.
- R10: After reset, entry 0 holds an all-ones mask and every other entry holds zero, all in mode 0. `rsp_valid` is 0 and `rsp_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_idx | input | IDX_W | Target entry |
| cmd_mask | input | WAYS | Requested way mask |
| cmd_mode | input | 2 | 0 shareable, 1 exclusive, 2 pseudo-lock |
| full_mask | input | WAYS | Ways that exist |
| min_run | input | RUN_W | Minimum consecutive set bits |
| need_contig | input | 1 | Require a single run of set bits |
| hw_share_mask | input | WAYS | Ways also used by hardware agents |
| rd_idx | input | IDX_W | Entry shown on the read port |
| rsp_valid | output | 1 | Verdict strobe |
| rsp_ok | output | 1 | Latched verdict is accept |
| rsp_err | output | 3 | Latched error code |
| rd_mask | output | WAYS | Mask of the selected entry |
| rd_mode | output | 2 | Mode of the selected entry |
| usage | output | 3*WAYS | Per-way usage codes |

## Verification
A command sampled at one rising edge produces its verdict, its table update and the new usage codes together, all visible right after that same edge. The read port and the usage vector have no further register stage. The bench therefore drives each command on a falling edge and samples every result on the next falling edge, which is exactly one register later. It then checks one cycle further on that `rsp_valid` has dropped while `rsp_err` is unchanged.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  typedef enum logic [1:0] {
    MODE_SHARE = 2'd0,
    MODE_EXCL  = 2'd1,
    MODE_PLOCK = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    ERR_OK         = 3'd0,
    ERR_NONCONTIG  = 3'd1,
    ERR_TOOFEW     = 3'd2,
    ERR_RANGE      = 3'd3,
    ERR_OVL_EXCL   = 3'd4,
    ERR_NOT_UNUSED = 3'd5
  } err_e;

  localparam logic [2:0] USE_FREE   = 3'd0;
  localparam logic [2:0] USE_HW     = 3'd1;
  localparam logic [2:0] USE_HWSW   = 3'd2;
  localparam logic [2:0] USE_SW     = 3'd3;
  localparam logic [2:0] USE_EXCL   = 3'd4;
  localparam logic [2:0] USE_LOCKED = 3'd5;
endpackage

// File: rtl/cbm_shape_chk.sv
module cbm_shape_chk #(
  parameter int WAYS  = 8,
  parameter int RUN_W = 4
) (
  input  logic [WAYS-1:0]  mask,
  input  logic [WAYS-1:0]  full_mask,
  input  logic [RUN_W-1:0] min_run,
  input  logic             need_contig,
  output logic             bad_range,
  output logic             too_short,
  output logic             broken
);
  logic [RUN_W-1:0] best_run;
  int               run_starts;

  // Longest run and number of runs, scanned from bit 0 upward
  always_comb begin
    logic [RUN_W-1:0] cur;
    logic             prev;
    cur        = '0;
    best_run   = '0;
    run_starts = 0;
    prev       = 1'b0;
    for (int b = 0; b < WAYS; b++) begin
      if (mask[b]) begin
        cur = cur + 1'b1;
        if (cur > best_run) best_run = cur;
        if (!prev) run_starts = run_starts + 1;
      end else begin
        cur = '0;
      end
      prev = mask[b];
    end
  end

  assign bad_range = |(mask & ~full_mask);
  assign too_short = (best_run < min_run);
  assign broken    = need_contig && (run_starts > 1);
endmodule

// File: rtl/cbm_table.sv
module cbm_table #(
  parameter int WAYS    = 8,
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [WAYS-1:0]                 wr_mask,
  input  logic [1:0]                      wr_mode,
  output logic [ENTRIES-1:0][WAYS-1:0]    ent_mask,
  output logic [ENTRIES-1:0][1:0]         ent_mode
);
  logic [ENTRIES-1:0][WAYS-1:0] mask_q, mask_d;
  logic [ENTRIES-1:0][1:0]      mode_q, mode_d;

  always_comb begin
    mask_d = mask_q;
    mode_d = mode_q;
    if (wr_en) begin
      mask_d[wr_idx] = wr_mask;
      mode_d[wr_idx] = wr_mode;
    end
  end

  // Entry 0 is the default class and owns every way out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= {{((ENTRIES-1)*WAYS){1'b0}}, {WAYS{1'b1}}};
      mode_q <= '0;
    end else if (wr_en) begin
      mask_q <= mask_d;
      mode_q <= mode_d;
    end
  end

  assign ent_mask = mask_q;
  assign ent_mode = mode_q;
endmodule

// File: rtl/cbm_usage_map.sv
module cbm_usage_map
  import cbm_pkg::*;
#(
  parameter int WAYS    = 8,
  parameter int ENTRIES = 4
) (
  input  logic [ENTRIES-1:0][WAYS-1:0] ent_mask,
  input  logic [ENTRIES-1:0][1:0]      ent_mode,
  input  logic [WAYS-1:0]              hw_share_mask,
  output logic [3*WAYS-1:0]            usage
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic held_lock, held_excl, held_share;

    always_comb begin
      held_lock  = 1'b0;
      held_excl  = 1'b0;
      held_share = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
        if (ent_mask[e][w]) begin
          if (ent_mode[e] == MODE_PLOCK)     held_lock  = 1'b1;
          else if (ent_mode[e] == MODE_EXCL) held_excl  = 1'b1;
          else                               held_share = 1'b1;
        end
      end
    end

    always_comb begin
      if (held_lock)             usage[3*w +: 3] = USE_LOCKED;
      else if (held_excl)        usage[3*w +: 3] = USE_EXCL;
      else if (held_share)       usage[3*w +: 3] = hw_share_mask[w] ? USE_HWSW : USE_SW;
      else if (hw_share_mask[w]) usage[3*w +: 3] = USE_HW;
      else                       usage[3*w +: 3] = USE_FREE;
    end
  end
endmodule

// File: rtl/cbm_mask_checker.sv
module cbm_mask_checker
  import cbm_pkg::*;
#(
  parameter int WAYS    = 8,
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int RUN_W  = $clog2(WAYS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [IDX_W-1:0]   cmd_idx,
  input  logic [WAYS-1:0]    cmd_mask,
  input  logic [1:0]         cmd_mode,
  input  logic [WAYS-1:0]    full_mask,
  input  logic [RUN_W-1:0]   min_run,
  input  logic               need_contig,
  input  logic [WAYS-1:0]    hw_share_mask,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rsp_valid,
  output logic               rsp_ok,
  output logic [2:0]         rsp_err,
  output logic [WAYS-1:0]    rd_mask,
  output logic [1:0]         rd_mode,
  output logic [3*WAYS-1:0]  usage
);
  logic [ENTRIES-1:0][WAYS-1:0] ent_mask;
  logic [ENTRIES-1:0][1:0]      ent_mode;
  logic                         bad_range, too_short, broken;
  logic [WAYS-1:0]              others_any, others_held;
  err_e                         verdict;
  logic [1:0]                   store_mode;
  logic                         wr_en;
  logic                         valid_q, valid_d;
  err_e                         err_q, err_d;

  cbm_shape_chk #(.WAYS(WAYS), .RUN_W(RUN_W)) u_shape (
    .mask        (cmd_mask),
    .full_mask   (full_mask),
    .min_run     (min_run),
    .need_contig (need_contig),
    .bad_range   (bad_range),
    .too_short   (too_short),
    .broken      (broken)
  );

  // Union of the other entries' masks, all and held (exclusive or locked)
  always_comb begin
    others_any  = '0;
    others_held = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (IDX_W'(e) != cmd_idx) begin
        others_any = others_any | ent_mask[e];
        if (ent_mode[e] != MODE_SHARE) others_held = others_held | ent_mask[e];
      end
    end
  end

  // Shape checks rank above conflict checks
  always_comb begin
    verdict = ERR_OK;
    if (bad_range)      verdict = ERR_RANGE;
    else if (too_short) verdict = ERR_TOOFEW;
    else if (broken)    verdict = ERR_NONCONTIG;
    else begin
      case (cmd_mode)
        MODE_PLOCK: if (|(cmd_mask & (others_any | hw_share_mask))) verdict = ERR_NOT_UNUSED;
        MODE_EXCL:  if (|(cmd_mask & others_any))                   verdict = ERR_OVL_EXCL;
        default:    if (|(cmd_mask & others_held))                  verdict = ERR_OVL_EXCL;
      endcase
    end
  end

  assign store_mode = (cmd_mode == MODE_EXCL || cmd_mode == MODE_PLOCK) ? cmd_mode : MODE_SHARE;
  assign wr_en      = cmd_valid && (verdict == ERR_OK);

  cbm_table #(.WAYS(WAYS), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (cmd_idx),
    .wr_mask  (cmd_mask),
    .wr_mode  (store_mode),
    .ent_mask (ent_mask),
    .ent_mode (ent_mode)
  );

  cbm_usage_map #(.WAYS(WAYS), .ENTRIES(ENTRIES)) u_usage (
    .ent_mask      (ent_mask),
    .ent_mode      (ent_mode),
    .hw_share_mask (hw_share_mask),
    .usage         (usage)
  );

  always_comb begin
    valid_d = cmd_valid;
    err_d   = cmd_valid ? verdict : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= ERR_OK;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_err   = err_q;
  assign rsp_ok    = (err_q == ERR_OK);
  assign rd_mask   = ent_mask[rd_idx];
  assign rd_mode   = ent_mode[rd_idx];
endmodule

// File: rtl/cbm_mask_checker_sva.sv
module cbm_mask_checker_sva #(
  parameter int WAYS    = 8,
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cmd_valid,
  input logic [IDX_W-1:0]             cmd_idx,
  input logic [WAYS-1:0]              cmd_mask,
  input logic                         rsp_valid,
  input logic [2:0]                   rsp_err,
  input logic [ENTRIES-1:0][WAYS-1:0] ent_mask,
  input logic [ENTRIES-1:0][1:0]      ent_mode,
  input logic [3*WAYS-1:0]            usage
);
  logic [IDX_W-1:0] last_idx;
  logic [WAYS-1:0]  last_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_idx  <= '0;
      last_mask <= '0;
    end else if (cmd_valid) begin
      last_idx  <= cmd_idx;
      last_mask <= cmd_mask;
    end
  end

  p_rsp_follows_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);

  p_rsp_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);

  p_err_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(rsp_err));

  p_reject_keeps_table_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err != 3'd0) |-> ($stable(ent_mask) && $stable(ent_mode)));

  p_accept_stores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err == 3'd0) |-> (ent_mask[last_idx] == last_mask));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_own
    for (genvar j = 0; j < ENTRIES; j++) begin : g_other
      if (i != j) begin : g_pair
        p_held_disjoint_r6: assert property (@(posedge clk) disable iff (!rst_n)
          (ent_mode[i] != 2'd0) |-> ((ent_mask[i] & ent_mask[j]) == '0));
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_code
    p_usage_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      usage[3*w +: 3] <= 3'd5);
  end
endmodule

bind cbm_mask_checker cbm_mask_checker_sva #(
  .WAYS(WAYS), .ENTRIES(ENTRIES), .IDX_W(IDX_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_idx   (cmd_idx),
  .cmd_mask  (cmd_mask),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .ent_mask  (ent_mask),
  .ent_mode  (ent_mode),
  .usage     (usage)
);

// File: tb/sim_cbm_mask_checker.sv
`timescale 1ns/1ps
module sim_cbm_mask_checker;
  localparam int W = 8;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid;
  logic [1:0]   cmd_idx;
  logic [W-1:0] cmd_mask;
  logic [1:0]   cmd_mode;
  logic [W-1:0] full_mask;
  logic [3:0]   min_run;
  logic         need_contig;
  logic [W-1:0] hw_share_mask;
  logic [1:0]   rd_idx;
  logic         rsp_valid, rsp_ok;
  logic [2:0]   rsp_err;
  logic [W-1:0] rd_mask;
  logic [1:0]   rd_mode;
  logic [3*W-1:0] usage;

  int n_tests = 0;
  int n_fail  = 0;
  logic [W-1:0] mdl_mask [N];
  int           mdl_mode [N];

  always #10 clk = ~clk;

  cbm_mask_checker #(.WAYS(W), .ENTRIES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
    .cmd_mask(cmd_mask), .cmd_mode(cmd_mode), .full_mask(full_mask),
    .min_run(min_run), .need_contig(need_contig), .hw_share_mask(hw_share_mask),
    .rd_idx(rd_idx), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_err(rsp_err),
    .rd_mask(rd_mask), .rd_mode(rd_mode), .usage(usage)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Each AND with a one-bit shift shortens every run by one
  function automatic int longest(input logic [W-1:0] m);
    logic [W-1:0] t;
    int n;
    t = m;
    n = 0;
    while (t != '0) begin
      t = t & (t >> 1);
      n++;
    end
    return n;
  endfunction

  // Adding the lowest set bit clears a single run completely
  function automatic bit one_run(input logic [W-1:0] m);
    logic [W:0] low, sum;
    if (m == '0) return 1'b1;
    low = {1'b0, m & (~m + 1'b1)};
    sum = {1'b0, m} + low;
    return (sum & {1'b0, m}) == '0;
  endfunction

  function automatic int model_err(input int idx, input logic [W-1:0] m, input int md,
                                   input logic [W-1:0] full, input int minr, input bit contig);
    logic [W-1:0] any, held;
    any = '0;
    held = '0;
    if ((m & ~full) != '0) return 3;
    if (longest(m) < minr) return 2;
    if (contig && !one_run(m)) return 1;
    for (int e = 0; e < N; e++) begin
      if (e != idx) begin
        any = any | mdl_mask[e];
        if (mdl_mode[e] != 0) held = held | mdl_mask[e];
      end
    end
    if (md == 2) return ((m & (any | hw_share_mask)) != '0) ? 5 : 0;
    if (md == 1) return ((m & any) != '0) ? 4 : 0;
    return ((m & held) != '0) ? 4 : 0;
  endfunction

  function automatic logic [3*W-1:0] model_usage();
    logic [3*W-1:0] u;
    for (int w = 0; w < W; w++) begin
      int code;
      bit lk, ex, sh;
      lk = 0; ex = 0; sh = 0;
      for (int e = 0; e < N; e++) begin
        if (mdl_mask[e][w]) begin
          if (mdl_mode[e] == 2) lk = 1;
          else if (mdl_mode[e] == 1) ex = 1;
          else sh = 1;
        end
      end
      if (lk) code = 5;
      else if (ex) code = 4;
      else if (sh) code = hw_share_mask[w] ? 2 : 3;
      else code = hw_share_mask[w] ? 1 : 0;
      u[3*w +: 3] = 3'(code);
    end
    return u;
  endfunction

  task automatic do_cmd(input int idx, input logic [W-1:0] m, input int md,
                        input logic [W-1:0] full, input int minr, input bit contig);
    int    e_err;
    string tag;
    e_err = model_err(idx, m, md, full, minr, contig);
    case (e_err)
      0: tag = "R8";
      1: tag = "R4";
      2: tag = "R3";
      3: tag = "R2";
      4: tag = (md == 1) ? "R6" : "R5";
      default: tag = "R7";
    endcase
    @(negedge clk);
    cmd_valid   = 1'b1;
    cmd_idx     = 2'(idx);
    cmd_mask    = m;
    cmd_mode    = 2'(md);
    full_mask   = full;
    min_run     = 4'(minr);
    need_contig = contig;
    rd_idx      = 2'(idx);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (e_err == 0) begin
      mdl_mask[idx] = m;
      mdl_mode[idx] = (md == 3) ? 0 : md;
    end
    check("R1 rsp_valid pulse", rsp_valid, 1);
    check(tag, rsp_err, e_err);
    check("R8 rsp_ok", rsp_ok, e_err == 0);
    check("R8 rd_mask", rd_mask, mdl_mask[idx]);
    check((md == 2) ? "R7 rd_mode" : "R8 rd_mode", rd_mode, mdl_mode[idx]);
    check("R9 usage", usage, model_usage());
    @(negedge clk);
    check("R1 rsp_valid drop", rsp_valid, 0);
    check("R1 err held", rsp_err, e_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_idx = '0; cmd_mask = '0; cmd_mode = '0;
    full_mask = 8'hFF; min_run = 4'd1; need_contig = 1'b1;
    hw_share_mask = 8'hC0; rd_idx = '0;
    mdl_mask[0] = 8'hFF; mdl_mode[0] = 0;
    for (int e = 1; e < N; e++) begin
      mdl_mask[e] = '0;
      mdl_mode[e] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 rsp_valid", rsp_valid, 0);
    check("R10 rsp_err", rsp_err, 0);
    check("R10 entry0 mask", rd_mask, 8'hFF);
    check("R10 entry0 mode", rd_mode, 0);
    rd_idx = 2'd2;
    @(negedge clk);
    check("R10 entry2 mask", rd_mask, 8'h00);
    check("R10 usage", usage, model_usage());

    // R4 contiguity examples, then R6/R5/R7 conflicts
    do_cmd(1, 8'h05, 0, 8'hFF, 1, 1);
    do_cmd(1, 8'h06, 0, 8'hFF, 1, 1);
    do_cmd(2, 8'h30, 1, 8'hFF, 1, 1);
    do_cmd(0, 8'h0F, 0, 8'hFF, 1, 1);
    do_cmd(2, 8'h30, 1, 8'hFF, 1, 1);
    do_cmd(0, 8'h20, 0, 8'hFF, 1, 1);
    do_cmd(3, 8'h80, 2, 8'hFF, 1, 1);
    do_cmd(1, 8'h00, 0, 8'hFF, 0, 1);
    do_cmd(3, 8'h06, 2, 8'hFF, 1, 1);
    do_cmd(1, 8'h00, 0, 8'hFF, 1, 1);
    do_cmd(1, 8'h02, 0, 8'hFF, 2, 0);
    do_cmd(1, 8'h81, 0, 8'h7F, 1, 0);

    // Sweep every mask under each requested mode with varied limits
    for (int m = 0; m < 256; m++) begin
      for (int md = 0; md < 3; md++) begin
        do_cmd((m + md) % N, 8'(m), md,
               ((m / 16) % 3 == 0) ? 8'h7F : 8'hFF,
               (m + md) % 4, ((m / 8) % 2) == 1);
      end
      if (m % 16 == 15) begin
        for (int e = 0; e < N; e++) do_cmd(e, 8'h00, 0, 8'hFF, 0, 0);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule